// File: doc/BRIEF.md
# Linked-Descriptor Memory-to-Stream Engine

The engine moves buffers from memory onto a 32-bit data stream by following a chain of descriptors held in memory. Each descriptor is eight 32-bit words: next pointer (low word at byte offset 0, high word at 4), buffer address (low word at 8, high word at 12), two reserved words (16, 20), a control word (24) and a status word (28). Five application words follow at offsets 32 to 48. All words are little-endian, and only the low 32 bits of each pointer are used. The control word holds the byte count in bits 22:0, the frame-end flag in bit 26 and the frame-start flag in bit 27. Status bit 31 marks a descriptor as already done.

A controller loads the starting pointer with `go_i` and moves the stop point with `tail_wr_i`. The engine runs while `run_i` is high. For each descriptor it reads the header, sends the application words on a side control stream when the descriptor opens a frame, and streams the buffer out. It then writes the status word back and follows the next pointer. The walk stops once the descriptor at the tail address has been handled. A frame-end descriptor raises `frame_done_o` for the event-coalescing logic outside the block. A fetch that fails raises a decode-error or slave-error pulse and halts the engine.

The controller is one state machine. Its states are PARK (wait), FETCH (read eight header words), DECODE, APP_RD/APP_TX (read and send one application word), DATA_RD/DATA_TX (read and send one buffer word), WBACK (status write) and NEXT (advance). The transitions are:
- PARK→FETCH when running, not halted and not idle.
- FETCH→DECODE on the eighth grant.
- FETCH/APP_RD→PARK on an error response.
- DECODE→PARK on a descriptor that is already done.
- DECODE→APP_RD on frame start.
- DECODE→DATA_RD or →WBACK (zero length) otherwise.
- APP_TX→APP_RD, or →DATA_RD/WBACK after the fifth word.
- DATA_TX→DATA_RD, or →WBACK when no bytes remain.
- WBACK→NEXT on grant.
- NEXT→PARK.

Top module: `sgx_engine`

## Requirements
- R1: After reset `halted_o` is 1, `idle_o` is 0, and no memory request or stream beat is presented.
- R2: `go_i` in PARK loads the current pointer from `start_ptr_i` and clears halted and idle. No descriptor is fetched while `run_i` is 0.
- R3: A fetched descriptor whose status word (offset 28) has bit 31 set sets `halted_o`. It produces no stream beat and no status write.
- R4: When control bit 27 is set, the five words at offsets 32..48 go out in order on the control stream, the fifth with `ctl_tlast_o`. All of them go out before the descriptor's first data beat.
- R5: The buffer is sent as length (control bits 22:0) bytes in 32-bit beats, lowest byte first. The final partial beat has `dat_tkeep_o` set to 4'b0001, 4'b0011 or 4'b0111. `dat_tlast_o` is set only on the final beat of a descriptor with control bit 26 set.
- R6: After the data, the engine writes 32'h8000_0000 (done flag, zero remaining) to the descriptor's offset 28.
- R7: After the status write, the current pointer takes the next pointer (offset 0). If the descriptor just handled sat at the tail address, `idle_o` is set and the walk stops.
- R8: Each completed descriptor with control bit 26 set gives exactly one single-cycle `frame_done_o` pulse.
- R9: A fetch response of 2'b10 pulses `err_dec_o`, and 2'b01 or 2'b11 pulses `err_slv_o`. Either response sets `halted_o`.
- R10: A stream beat held with valid and no ready keeps its payload unchanged. No beat is lost or duplicated under back-pressure.
- R11: `tail_wr_i` updates the tail address and clears idle. The walk then resumes from the current pointer.
- R12: A memory request stays asserted with unchanged address and direction until `mem_gnt_i`. Read data and response are taken in the grant cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Allows new descriptors to start |
| go_i | input | 1 | Load start pointer, clear halted and idle |
| start_ptr_i | input | ADDR_W | Starting descriptor address |
| tail_wr_i | input | 1 | Load tail address, clear idle |
| tail_ptr_i | input | ADDR_W | Last descriptor address to process |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | ADDR_W | Byte address (word aligned) |
| mem_wdata_o | output | 32 | Write data |
| mem_gnt_i | input | 1 | Request accepted this cycle |
| mem_rdata_i | input | 32 | Read data, valid with grant |
| mem_resp_i | input | 2 | Response: 00 ok, 01 slave error, 10 decode error |
| ctl_tvalid_o | output | 1 | Control stream valid |
| ctl_tready_i | input | 1 | Control stream ready |
| ctl_tdata_o | output | 32 | Application word |
| ctl_tlast_o | output | 1 | Fifth application word |
| dat_tvalid_o | output | 1 | Data stream valid |
| dat_tready_i | input | 1 | Data stream ready |
| dat_tdata_o | output | 32 | Buffer word |
| dat_tkeep_o | output | 4 | Valid byte lanes |
| dat_tlast_o | output | 1 | End of frame |
| frame_done_o | output | 1 | Frame-end descriptor completed |
| err_dec_o | output | 1 | Decode error on fetch |
| err_slv_o | output | 1 | Slave error on fetch |
| idle_o | output | 1 | Tail reached |
| halted_o | output | 1 | Stopped by reset, done descriptor or error |
| cur_ptr_o | output | ADDR_W | Current descriptor address |

## Verification
The assertions check on every cycle that memory requests are held until granted. They also check that stream payloads stay stable under back-pressure, that no beat is loaded over a pending one, that data never starts while an application word is pending, that error pulses coincide with the halted state, and that completion never overlaps a memory access. Only the bench scenarios can show the rest: the exact beat sequence, keep and last values across several descriptor shapes, the status words written back, the pointer and idle state after a chain, tail extension, the halt on a descriptor that is already done, and recovery after both error kinds.

// File: rtl/sgx_pkg.sv
package sgx_pkg;

    typedef enum logic [3:0] {
        ST_PARK,
        ST_FETCH,
        ST_DECODE,
        ST_APP_RD,
        ST_APP_TX,
        ST_DATA_RD,
        ST_DATA_TX,
        ST_WBACK,
        ST_NEXT
    } sgx_state_e;

    localparam logic [1:0] RESP_OK  = 2'b00;
    localparam logic [1:0] RESP_DEC = 2'b10;

    localparam int LEN_W         = 23;
    localparam int CTL_EOF_BIT   = 26;
    localparam int CTL_SOF_BIT   = 27;
    localparam int STAT_DONE_BIT = 31;
    localparam int HDR_WORDS     = 8;
    localparam int APP_WORDS     = 5;
    localparam int IDX_W         = $clog2(HDR_WORDS);
    localparam int CTL_BEAT_W    = 33;  // {last, data}
    localparam int DAT_BEAT_W    = 37;  // {last, keep, data}

    // byte lanes valid for the beat that carries the remaining count
    function automatic logic [3:0] lanes_for(input logic [LEN_W-1:0] rem);
        if (rem >= LEN_W'(4)) return 4'hF;
        unique case (rem[1:0])
            2'd1:    return 4'h1;
            2'd2:    return 4'h3;
            2'd3:    return 4'h7;
            default: return 4'hF;
        endcase
    endfunction

endpackage

// File: rtl/sgx_beat_slot.sv
module sgx_beat_slot #(
    parameter int W = 33
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] beat_i,
    input  logic         ready_i,
    output logic         valid_o,
    output logic [W-1:0] beat_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            beat_o  <= '0;
        end else if (load_i) begin
            valid_o <= 1'b1;
            beat_o  <= beat_i;
        end else if (ready_i) begin
            valid_o <= 1'b0;
        end
    end

    // R10: a pending beat is neither dropped nor altered
    a_r10_beat_hold: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o && !ready_i |=> valid_o && $stable(beat_o));

    // R10: the controller never overwrites a beat still waiting
    a_r10_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> !valid_o);

endmodule

// File: rtl/sgx_walk_fsm.sv
module sgx_walk_fsm
    import sgx_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  run_i,
    input  logic                  go_i,
    input  logic [ADDR_W-1:0]     start_ptr_i,
    input  logic                  tail_wr_i,
    input  logic [ADDR_W-1:0]     tail_ptr_i,
    output logic                  mem_req_o,
    output logic                  mem_we_o,
    output logic [ADDR_W-1:0]     mem_addr_o,
    output logic [31:0]           mem_wdata_o,
    input  logic                  mem_gnt_i,
    input  logic [31:0]           mem_rdata_i,
    input  logic [1:0]            mem_resp_i,
    output logic                  ctl_load_o,
    output logic [CTL_BEAT_W-1:0] ctl_beat_o,
    input  logic                  ctl_busy_i,
    output logic                  dat_load_o,
    output logic [DAT_BEAT_W-1:0] dat_beat_o,
    input  logic                  dat_busy_i,
    output logic                  frame_done_o,
    output logic                  err_dec_o,
    output logic                  err_slv_o,
    output logic                  idle_o,
    output logic                  halted_o,
    output logic [ADDR_W-1:0]     cur_ptr_o
);

    localparam logic [ADDR_W-1:0] OFS_STATUS = ADDR_W'(28);
    localparam logic [ADDR_W-1:0] OFS_APP    = ADDR_W'(32);
    localparam logic [IDX_W-1:0]  IDX_LAST   = IDX_W'(HDR_WORDS - 1);
    localparam logic [IDX_W-1:0]  APP_LAST   = IDX_W'(APP_WORDS - 1);

    sgx_state_e state_q, state_d;

    logic [ADDR_W-1:0] cur_q, tail_q, nxt_q, buf_q, addr_q;
    logic [31:0]       ctrl_q, stat_q;
    logic [IDX_W-1:0]  idx_q;
    logic [LEN_W-1:0]  remain_q;
    logic              halted_q, idle_q, done_q, edec_q, eslv_q;

    logic             resp_bad;
    logic             may_start;
    logic [LEN_W-1:0] step;
    logic [LEN_W-1:0] len_field;

    assign resp_bad  = (mem_resp_i != RESP_OK);
    assign may_start = run_i && !halted_q && !idle_q;
    assign step      = (remain_q >= LEN_W'(4)) ? LEN_W'(4) : remain_q;
    assign len_field = ctrl_q[LEN_W-1:0];

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_PARK:    if (!go_i && may_start) state_d = ST_FETCH;
            ST_FETCH:   if (mem_gnt_i) begin
                            if (resp_bad)              state_d = ST_PARK;
                            else if (idx_q == IDX_LAST) state_d = ST_DECODE;
                        end
            ST_DECODE:  if (stat_q[STAT_DONE_BIT])      state_d = ST_PARK;
                        else if (ctrl_q[CTL_SOF_BIT])   state_d = ST_APP_RD;
                        else if (len_field == '0)       state_d = ST_WBACK;
                        else                            state_d = ST_DATA_RD;
            ST_APP_RD:  if (mem_gnt_i) state_d = resp_bad ? ST_PARK : ST_APP_TX;
            ST_APP_TX:  if (!ctl_busy_i) begin
                            if (idx_q != APP_LAST)      state_d = ST_APP_RD;
                            else if (len_field == '0)   state_d = ST_WBACK;
                            else                        state_d = ST_DATA_RD;
                        end
            ST_DATA_RD: if (mem_gnt_i) state_d = ST_DATA_TX;
            ST_DATA_TX: if (!dat_busy_i)
                            state_d = (remain_q == '0) ? ST_WBACK : ST_DATA_RD;
            ST_WBACK:   if (mem_gnt_i) state_d = ST_NEXT;
            ST_NEXT:    state_d = ST_PARK;
            default:    state_d = ST_PARK;
        endcase
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_PARK;
        else        state_q <= state_d;
    end

    // ---------------- datapath ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q    <= '0;
            tail_q   <= '0;
            nxt_q    <= '0;
            buf_q    <= '0;
            addr_q   <= '0;
            ctrl_q   <= '0;
            stat_q   <= '0;
            idx_q    <= '0;
            remain_q <= '0;
            halted_q <= 1'b1;
            idle_q   <= 1'b0;
            done_q   <= 1'b0;
            edec_q   <= 1'b0;
            eslv_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            edec_q <= 1'b0;
            eslv_q <= 1'b0;
            unique case (state_q)
                ST_PARK: begin
                    if (go_i) begin
                        cur_q    <= start_ptr_i;
                        halted_q <= 1'b0;
                        idle_q   <= 1'b0;
                    end else if (may_start) begin
                        idx_q <= '0;
                    end
                end
                ST_FETCH: begin
                    if (mem_gnt_i) begin
                        if (resp_bad) begin
                            halted_q <= 1'b1;
                            edec_q   <= (mem_resp_i == RESP_DEC);
                            eslv_q   <= (mem_resp_i != RESP_DEC);
                        end else begin
                            unique case (idx_q)
                                IDX_W'(0): nxt_q  <= mem_rdata_i[ADDR_W-1:0];
                                IDX_W'(2): buf_q  <= mem_rdata_i[ADDR_W-1:0];
                                IDX_W'(6): ctrl_q <= mem_rdata_i;
                                IDX_W'(7): stat_q <= mem_rdata_i;
                                default: ;
                            endcase
                            idx_q <= idx_q + 1'b1;
                        end
                    end
                end
                ST_DECODE: begin
                    idx_q    <= '0;
                    addr_q   <= buf_q;
                    remain_q <= len_field;
                    if (stat_q[STAT_DONE_BIT]) halted_q <= 1'b1;
                end
                ST_APP_RD: begin
                    if (mem_gnt_i && resp_bad) begin
                        halted_q <= 1'b1;
                        edec_q   <= (mem_resp_i == RESP_DEC);
                        eslv_q   <= (mem_resp_i != RESP_DEC);
                    end
                end
                ST_APP_TX: begin
                    if (!ctl_busy_i && idx_q != APP_LAST) idx_q <= idx_q + 1'b1;
                end
                ST_DATA_RD: begin
                    if (mem_gnt_i) begin
                        addr_q   <= addr_q + ADDR_W'(4);
                        remain_q <= remain_q - step;
                    end
                end
                ST_DATA_TX: ;
                ST_WBACK: begin
                    if (mem_gnt_i) done_q <= ctrl_q[CTL_EOF_BIT];
                end
                ST_NEXT: begin
                    cur_q <= nxt_q;
                    if (cur_q == tail_q) idle_q <= 1'b1;
                end
                default: ;
            endcase
            if (tail_wr_i) begin
                tail_q <= tail_ptr_i;
                idle_q <= 1'b0;
            end
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        mem_req_o   = 1'b0;
        mem_we_o    = 1'b0;
        mem_addr_o  = '0;
        mem_wdata_o = {1'b1, 8'h00, remain_q};
        ctl_load_o  = 1'b0;
        dat_load_o  = 1'b0;
        unique case (state_q)
            ST_FETCH: begin
                mem_req_o  = 1'b1;
                mem_addr_o = cur_q + ADDR_W'({idx_q, 2'b00});
            end
            ST_APP_RD: begin
                mem_req_o  = 1'b1;
                mem_addr_o = cur_q + OFS_APP + ADDR_W'({idx_q, 2'b00});
                ctl_load_o = mem_gnt_i && !resp_bad;
            end
            ST_DATA_RD: begin
                mem_req_o  = 1'b1;
                mem_addr_o = addr_q;
                dat_load_o = mem_gnt_i;
            end
            ST_WBACK: begin
                mem_req_o  = 1'b1;
                mem_we_o   = 1'b1;
                mem_addr_o = cur_q + OFS_STATUS;
            end
            default: ;
        endcase
    end

    assign ctl_beat_o   = {(idx_q == APP_LAST), mem_rdata_i};
    assign dat_beat_o   = {(ctrl_q[CTL_EOF_BIT] && remain_q <= LEN_W'(4)),
                           lanes_for(remain_q), mem_rdata_i};
    assign frame_done_o = done_q;
    assign err_dec_o    = edec_q;
    assign err_slv_o    = eslv_q;
    assign idle_o       = idle_q;
    assign halted_o     = halted_q;
    assign cur_ptr_o    = cur_q;

    // R12: request, address and direction held until granted
    a_r12_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o && !mem_gnt_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));

    // R9: an error event always leaves the engine halted
    a_r9_err_halts: assert property (@(posedge clk) disable iff (!rst_n)
        err_dec_o || err_slv_o |-> halted_o);

    // R9: at most one error kind per event
    a_r9_err_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({err_dec_o, err_slv_o}));

    // R8: the completion pulse lasts one cycle and overlaps no memory access
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done_o |-> !mem_req_o ##1 !frame_done_o);

    // R4: data never starts while an application word waits
    a_r4_app_before_data: assert property (@(posedge clk) disable iff (!rst_n)
        dat_load_o |-> !ctl_busy_i);

endmodule

// File: rtl/sgx_engine.sv
module sgx_engine
    import sgx_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic              go_i,
    input  logic [ADDR_W-1:0] start_ptr_i,
    input  logic              tail_wr_i,
    input  logic [ADDR_W-1:0] tail_ptr_i,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [31:0]       mem_wdata_o,
    input  logic              mem_gnt_i,
    input  logic [31:0]       mem_rdata_i,
    input  logic [1:0]        mem_resp_i,
    output logic              ctl_tvalid_o,
    input  logic              ctl_tready_i,
    output logic [31:0]       ctl_tdata_o,
    output logic              ctl_tlast_o,
    output logic              dat_tvalid_o,
    input  logic              dat_tready_i,
    output logic [31:0]       dat_tdata_o,
    output logic [3:0]        dat_tkeep_o,
    output logic              dat_tlast_o,
    output logic              frame_done_o,
    output logic              err_dec_o,
    output logic              err_slv_o,
    output logic              idle_o,
    output logic              halted_o,
    output logic [ADDR_W-1:0] cur_ptr_o
);

    logic                  ctl_load, dat_load;
    logic [CTL_BEAT_W-1:0] ctl_beat_in, ctl_beat_out;
    logic [DAT_BEAT_W-1:0] dat_beat_in, dat_beat_out;

    sgx_walk_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .run_i        (run_i),
        .go_i         (go_i),
        .start_ptr_i  (start_ptr_i),
        .tail_wr_i    (tail_wr_i),
        .tail_ptr_i   (tail_ptr_i),
        .mem_req_o    (mem_req_o),
        .mem_we_o     (mem_we_o),
        .mem_addr_o   (mem_addr_o),
        .mem_wdata_o  (mem_wdata_o),
        .mem_gnt_i    (mem_gnt_i),
        .mem_rdata_i  (mem_rdata_i),
        .mem_resp_i   (mem_resp_i),
        .ctl_load_o   (ctl_load),
        .ctl_beat_o   (ctl_beat_in),
        .ctl_busy_i   (ctl_tvalid_o),
        .dat_load_o   (dat_load),
        .dat_beat_o   (dat_beat_in),
        .dat_busy_i   (dat_tvalid_o),
        .frame_done_o (frame_done_o),
        .err_dec_o    (err_dec_o),
        .err_slv_o    (err_slv_o),
        .idle_o       (idle_o),
        .halted_o     (halted_o),
        .cur_ptr_o    (cur_ptr_o)
    );

    sgx_beat_slot #(.W(CTL_BEAT_W)) u_ctl_slot (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (ctl_load),
        .beat_i  (ctl_beat_in),
        .ready_i (ctl_tready_i),
        .valid_o (ctl_tvalid_o),
        .beat_o  (ctl_beat_out)
    );

    sgx_beat_slot #(.W(DAT_BEAT_W)) u_dat_slot (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (dat_load),
        .beat_i  (dat_beat_in),
        .ready_i (dat_tready_i),
        .valid_o (dat_tvalid_o),
        .beat_o  (dat_beat_out)
    );

    assign ctl_tlast_o = ctl_beat_out[32];
    assign ctl_tdata_o = ctl_beat_out[31:0];
    assign dat_tlast_o = dat_beat_out[36];
    assign dat_tkeep_o = dat_beat_out[35:32];
    assign dat_tdata_o = dat_beat_out[31:0];

endmodule

// File: tb/sgx_engine_bench.sv
module sgx_engine_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        run_i, go_i, tail_wr_i;
    logic [31:0] start_ptr_i, tail_ptr_i;
    logic        mem_req_o, mem_we_o, mem_gnt_i;
    logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata_i;
    logic [1:0]  mem_resp_i;
    logic        ctl_tvalid_o, ctl_tready_i, ctl_tlast_o;
    logic [31:0] ctl_tdata_o;
    logic        dat_tvalid_o, dat_tready_i, dat_tlast_o;
    logic [31:0] dat_tdata_o;
    logic [3:0]  dat_tkeep_o;
    logic        frame_done_o, err_dec_o, err_slv_o, idle_o, halted_o;
    logic [31:0] cur_ptr_o;

    always #10 clk = ~clk;

    sgx_engine u_sgx_engine (.*);

    logic [31:0] mem [0:511];
    logic [37:0] expq [$];      // {chan, last, keep, data}; chan 1 = control stream
    int total = 0, bad = 0;
    int n_done = 0, n_dec = 0, n_slv = 0, n_wr = 0, n_beats = 0, n_exp = 0;
    int cyc = 0;
    logic [31:0] err_addr = 32'hFFFF_FFFF;
    logic [1:0]  err_code = 2'b00;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // memory responder, stream sink and scoreboard monitor
    initial begin
        mem_gnt_i = 0; mem_rdata_i = 0; mem_resp_i = 0;
        ctl_tready_i = 0; dat_tready_i = 0;
        forever begin
            @(negedge clk);
            cyc++;
            mem_gnt_i = 0; mem_rdata_i = 0; mem_resp_i = 0;
            if (mem_req_o && (cyc % 3) != 0) begin
                mem_gnt_i = 1;
                if (mem_addr_o == err_addr) mem_resp_i = err_code;
                if (mem_we_o) begin
                    mem[mem_addr_o[10:2]] = mem_wdata_o;
                    n_wr++;
                end else mem_rdata_i = mem[mem_addr_o[10:2]];
            end
            ctl_tready_i = (cyc % 4) != 1;
            dat_tready_i = (cyc % 5) != 2;
            if (frame_done_o) n_done++;
            if (err_dec_o) n_dec++;
            if (err_slv_o) n_slv++;
            if (ctl_tvalid_o && ctl_tready_i) begin
                logic [37:0] got;
                got = {1'b1, ctl_tlast_o, 4'hF, ctl_tdata_o};
                n_beats++;
                if (expq.size() == 0) chk(0, "R4 unexpected control beat", got[31:0], 32'h0);
                else begin
                    logic [37:0] e;
                    e = expq.pop_front();
                    chk(got == e, "R4 control beat order/content", got[31:0], e[31:0]);
                end
            end
            if (dat_tvalid_o && dat_tready_i) begin
                logic [37:0] got;
                got = {1'b0, dat_tlast_o, dat_tkeep_o, dat_tdata_o};
                n_beats++;
                if (expq.size() == 0) chk(0, "R5 unexpected data beat", got[31:0], 32'h0);
                else begin
                    logic [37:0] e;
                    e = expq.pop_front();
                    chk(got == e, "R5 data beat keep/last/data", {got[37:32], got[25:0]}, {e[37:32], e[25:0]});
                end
            end
        end
    end

    // driver: place a descriptor and queue what it must produce
    task automatic put_desc(input logic [31:0] a, input logic [31:0] nxt, input logic [31:0] bufa,
                            input int len, input bit sof, input bit eof,
                            input logic [31:0] stat, input bit expect_out);
        int w;
        w = int'(a[10:2]);
        mem[w+0] = nxt;  mem[w+1] = 0;
        mem[w+2] = bufa; mem[w+3] = 0;
        mem[w+4] = 0;    mem[w+5] = 0;
        mem[w+6] = (32'(sof) << 27) | (32'(eof) << 26) | 32'(len);
        mem[w+7] = stat;
        for (int k = 0; k < 5; k++) mem[w+8+k] = 32'hC0DE_0000 + a + 32'(k);
        if (expect_out) begin
            if (sof)
                for (int k = 0; k < 5; k++) begin
                    expq.push_back({1'b1, (k == 4), 4'hF, mem[w+8+k]});
                    n_exp++;
                end
            for (int b = 0; b < (len + 3) / 4; b++) begin
                int rem;
                logic [3:0] kp;
                rem = len - 4 * b;
                kp = (rem >= 4) ? 4'hF : 4'((1 << rem) - 1);
                expq.push_back({1'b0, (eof && rem <= 4), kp, mem[int'(bufa[10:2]) + b]});
                n_exp++;
            end
        end
    endtask

    task automatic pulse_go(input logic [31:0] p);
        @(negedge clk); start_ptr_i = p; go_i = 1;
        @(negedge clk); go_i = 0;
    endtask

    task automatic pulse_tail(input logic [31:0] p);
        @(negedge clk); tail_ptr_i = p; tail_wr_i = 1;
        @(negedge clk); tail_wr_i = 0;
    endtask

    task automatic wait_stop();
        int n;
        n = 0;
        repeat (4) @(negedge clk);
        while (!((idle_o || halted_o) && !mem_req_o && !ctl_tvalid_o && !dat_tvalid_o) && n < 5000) begin
            @(negedge clk);
            n++;
        end
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 0; run_i = 0; go_i = 0; tail_wr_i = 0;
        start_ptr_i = 0; tail_ptr_i = 0;
        for (int i = 0; i < 512; i++) mem[i] = 32'h5A00_0000 ^ (32'(i) * 32'h0101_0101);
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1
        chk(halted_o == 1 && idle_o == 0, "R1 reset status", {halted_o, idle_o}, 2'b10);
        chk(!mem_req_o && !ctl_tvalid_o && !dat_tvalid_o, "R1 reset quiet",
            {mem_req_o, ctl_tvalid_o, dat_tvalid_o}, 0);

        // Scenario A: three-descriptor chain, mixed frame flags and lengths
        put_desc(32'h100, 32'h140, 32'h400, 10, 1, 0, 0, 1);
        put_desc(32'h140, 32'h180, 32'h500, 8,  0, 1, 0, 1);
        put_desc(32'h180, 32'h1C0, 32'h600, 5,  1, 1, 0, 1);
        pulse_tail(32'h180);
        pulse_go(32'h100);
        repeat (10) @(negedge clk);
        // R2
        chk(!mem_req_o, "R2 no fetch while run low", mem_req_o, 0);
        chk(halted_o == 0 && idle_o == 0, "R2 go clears halted", {halted_o, idle_o}, 0);
        chk(cur_ptr_o == 32'h100, "R2 pointer loaded", cur_ptr_o, 32'h100);
        run_i = 1;
        wait_stop();
        chk(expq.size() == 0, "R5 all beats of chain delivered", expq.size(), 0);
        chk(mem[(32'h100 >> 2) + 7] == 32'h8000_0000, "R6 status written D0", mem[(32'h100 >> 2) + 7], 32'h8000_0000);
        chk(mem[(32'h140 >> 2) + 7] == 32'h8000_0000, "R6 status written D1", mem[(32'h140 >> 2) + 7], 32'h8000_0000);
        chk(mem[(32'h180 >> 2) + 7] == 32'h8000_0000, "R6 status written D2", mem[(32'h180 >> 2) + 7], 32'h8000_0000);
        chk(idle_o == 1 && halted_o == 0, "R7 idle at tail", {idle_o, halted_o}, 2'b10);
        chk(cur_ptr_o == 32'h1C0, "R7 pointer advanced", cur_ptr_o, 32'h1C0);
        chk(n_done == 2, "R8 frame-end count", n_done, 2);

        // Scenario B: extend the tail by one descriptor
        put_desc(32'h1C0, 32'h200, 32'h700, 4, 1, 1, 0, 1);
        pulse_tail(32'h1C0);
        wait_stop();
        chk(expq.size() == 0, "R11 extension beats delivered", expq.size(), 0);
        chk(idle_o == 1 && cur_ptr_o == 32'h200, "R11 resumed to new tail", cur_ptr_o, 32'h200);
        chk(mem[(32'h1C0 >> 2) + 7] == 32'h8000_0000, "R6 status written D3", mem[(32'h1C0 >> 2) + 7], 32'h8000_0000);
        chk(n_done == 3, "R8 frame-end count after extension", n_done, 3);

        // Scenario C: descriptor already done halts the walk
        put_desc(32'h200, 32'h240, 32'h600, 8, 1, 1, 32'h8000_0123, 0);
        pulse_tail(32'h200);
        wait_stop();
        chk(halted_o == 1 && idle_o == 0, "R3 halted on done descriptor", {halted_o, idle_o}, 2'b10);
        chk(mem[(32'h200 >> 2) + 7] == 32'h8000_0123, "R3 status untouched", mem[(32'h200 >> 2) + 7], 32'h8000_0123);
        chk(cur_ptr_o == 32'h200, "R3 pointer kept", cur_ptr_o, 32'h200);
        chk(n_done == 3, "R3 no completion", n_done, 3);

        // Scenario D: fetch errors of both kinds, then recovery
        put_desc(32'h240, 32'h280, 32'h500, 6, 0, 1, 0, 0);
        err_addr = 32'h248; err_code = 2'b10;
        pulse_go(32'h240);
        wait_stop();
        chk(n_dec == 1 && n_slv == 0, "R9 decode error reported", {n_dec[15:0], n_slv[15:0]}, 32'h0001_0000);
        chk(halted_o == 1, "R9 halted after decode error", halted_o, 1);
        err_code = 2'b01;
        pulse_go(32'h240);
        wait_stop();
        chk(n_slv == 1 && n_dec == 1, "R9 slave error reported", {n_dec[15:0], n_slv[15:0]}, 32'h0001_0001);
        chk(halted_o == 1, "R9 halted after slave error", halted_o, 1);
        chk(mem[(32'h240 >> 2) + 7] == 32'h0, "R9 no status write on error", mem[(32'h240 >> 2) + 7], 0);
        err_addr = 32'hFFFF_FFFF; err_code = 2'b00;
        put_desc(32'h240, 32'h280, 32'h500, 6, 0, 1, 0, 1);
        pulse_tail(32'h240);
        pulse_go(32'h240);
        wait_stop();
        chk(idle_o == 1 && cur_ptr_o == 32'h280, "R9 recovery walk", cur_ptr_o, 32'h280);
        chk(n_done == 4, "R8 frame-end count final", n_done, 4);

        // R10 / R12: totals under stalls and back-pressure
        chk(n_beats == n_exp && expq.size() == 0, "R10 beats neither lost nor duplicated", n_beats, n_exp);
        chk(n_wr == 5, "R12 one granted status write per completed descriptor", n_wr, 5);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule